// File: doc/BRIEF.md
# Oversampled Bit Validity Checker

This block judges one bit cell of an asynchronous serial line. The framing logic places each cell by pulsing a start-of-cell strobe. After that strobe the checker takes the line value on each of the next 32 clock edges. The clock is the oversampling clock, so those 32 samples cover exactly one cell. When the window ends, the checker counts how many samples were HIGH. It then decides whether the cell was a clean HIGH, a clean LOW, or too noisy to trust.

The checker does not take a majority vote. It allows only a limited number of disagreeing samples, and software sets that limit through a 2-bit select with four settings. These settings correspond to roughly 19%, 25%, 31% and 37% of the cell. A sample count that lands between the two clean bands is reported as a bit error. The raw line passes through a two-flop synchronizer inside the block. The framing logic uses the one-cycle decision strobe to assemble characters and to count errors.

Top module: `bit_judge`

## Requirements
- R1: While reset is held and in the cycle after it is released, `bit_valid`, `bit_value` and `bit_error` are all 0.
- R2: The line passes through two synchronizer flops. The level driven on `serial_in` during the cycle ending one edge before the strobe edge is sample 1, and each later cycle supplies the next sample.
- R3: A strobe on `bit_start` opens a window of exactly 32 samples. The decision appears as a `bit_valid` pulse lasting exactly one cycle, in the cycle after the 32nd sample edge, which is the 33rd cycle after the strobe cycle.
- R4: The allowance of disagreeing samples is 6, 8, 10 or 12 for `tol_sel` codes 00, 01, 10 and 11.
- R5: If the HIGH count is at least 32 minus the allowance, the decision is `bit_value`=1 and `bit_error`=0.
- R6: If the HIGH count is at most the allowance, the decision is `bit_value`=0 and `bit_error`=0.
- R7: Any other HIGH count gives `bit_error`=1 and `bit_value`=0.
- R8: `tol_sel` is captured in the strobe cycle. Changing it later in the window does not alter that cell's decision.
- R9: A strobe arriving inside an open window restarts the window and discards the partial counts. The abandoned window produces no `bit_valid` pulse.
- R10: After a decision, `bit_valid` stays 0 until a new strobe opens a window and that window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 32 edges per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Raw serial line, asynchronous to clk |
| bit_start | input | 1 | One-cycle strobe marking the start of a bit cell |
| tol_sel | input | 2 | Tolerance code, captured with the strobe |
| bit_valid | output | 1 | One-cycle decision strobe |
| bit_value | output | 1 | Decided level, meaningful when bit_valid is high |
| bit_error | output | 1 | Set with bit_valid when the cell is ambiguous |

## Verification
The bench sweeps every HIGH count from 0 to 32 under every tolerance code. It places the HIGH samples both at the head and at the tail of the window. This exposes an off-by-one threshold, a swapped select code, or an error band on the wrong side of a boundary. Placing HIGH samples at the edges of the window catches a window that is shifted by one edge, or a synchronizer with the wrong number of stages; either fault miscounts those samples. One cell changes the select in mid-window: a design that reads the select live would give a different verdict. One cell gets a second strobe while a noisy window is open: a design that failed to clear its counts would report an error instead of a clean LOW, or would emit a stray pulse.

// File: rtl/bit_judge_pkg.sv
package bit_judge_pkg;

    typedef enum logic [1:0] {
        VERDICT_LOW  = 2'd0,
        VERDICT_HIGH = 2'd1,
        VERDICT_ERR  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic     valid;
        verdict_e verdict;
    } bit_result_t;

    // Disagreeing samples tolerated per cell; 6/8/10/12 for a 32-sample cell.
    function automatic int allow_count(input logic [1:0] sel, input int samples);
        return (samples * (6 + 2 * int'(sel))) / 32;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sample_tally.sv
module sample_tally
    import bit_judge_pkg::*;
#(
    parameter int SAMPLES = 32,
    localparam int CW = $clog2(SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    tol_sel,
    input  logic          sample,
    output logic          done,
    output logic [CW-1:0] ones_final,
    output logic [CW-1:0] allow
);
    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ones_q;
    logic [CW-1:0] allow_q;
    logic          last_edge;

    assign last_edge  = active_q && !start && (cnt_q == CW'(SAMPLES - 1));
    assign done       = last_edge;
    assign ones_final = ones_q + CW'(sample);
    assign allow      = allow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            ones_q   <= '0;
            allow_q  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            ones_q   <= '0;
            allow_q  <= CW'(allow_count(tol_sel, SAMPLES));
        end else if (active_q) begin
            cnt_q  <= cnt_q + 1'b1;
            ones_q <= ones_q + CW'(sample);
            if (last_edge) active_q <= 1'b0;
        end
    end

    // R3: the HIGH tally never runs ahead of the sample count
    assert_ones_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        ones_q <= cnt_q);
    // R3: an idle tally does not advance
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/verdict_unit.sv
module verdict_unit
    import bit_judge_pkg::*;
#(
    parameter int SAMPLES = 32,
    localparam int CW = $clog2(SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [CW-1:0] ones,
    input  logic [CW-1:0] allow,
    output bit_result_t   result
);
    verdict_e    verdict_c;
    bit_result_t result_q;

    always_comb begin
        if (ones >= CW'(SAMPLES) - allow) verdict_c = VERDICT_HIGH;
        else if (ones <= allow)          verdict_c = VERDICT_LOW;
        else                             verdict_c = VERDICT_ERR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '{valid: 1'b0, verdict: VERDICT_LOW};
        end else begin
            result_q.valid   <= done;
            result_q.verdict <= done ? verdict_c : VERDICT_LOW;
        end
    end

    assign result = result_q;

    // R3: decision strobe lasts a single cycle
    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        result_q.valid |=> !result_q.valid);
    // R7: a non-LOW verdict only accompanies a decision
    assert_verdict_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (result_q.verdict != VERDICT_LOW) |-> result_q.valid);
endmodule

// File: rtl/bit_judge.sv
module bit_judge
    import bit_judge_pkg::*;
#(
    parameter int SAMPLES     = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(SAMPLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       serial_in,
    input  logic       bit_start,
    input  logic [1:0] tol_sel,
    output logic       bit_valid,
    output logic       bit_value,
    output logic       bit_error
);
    logic          line_s;
    logic          done;
    logic [CW-1:0] ones_final;
    logic [CW-1:0] allow;
    bit_result_t   result;

    line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (serial_in),
        .q   (line_s)
    );

    sample_tally #(.SAMPLES(SAMPLES)) tally_i (
        .clk        (clk),
        .rst        (rst),
        .start      (bit_start),
        .tol_sel    (tol_sel),
        .sample     (line_s),
        .done       (done),
        .ones_final (ones_final),
        .allow      (allow)
    );

    verdict_unit #(.SAMPLES(SAMPLES)) verdict_i (
        .clk    (clk),
        .rst    (rst),
        .done   (done),
        .ones   (ones_final),
        .allow  (allow),
        .result (result)
    );

    assign bit_valid = result.valid;
    assign bit_value = (result.verdict == VERDICT_HIGH);
    assign bit_error = (result.verdict == VERDICT_ERR);

    // R9: a strobe cancels any decision that was about to be made
    assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> !bit_valid);
    // R7: error and HIGH are never reported together
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(bit_value && bit_error));
endmodule

// File: tb/bit_judge_tb_top.sv
module bit_judge_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_in = 1'b0;
    logic       bit_start = 1'b0;
    logic [1:0] tol_sel = 2'b00;
    logic       bit_valid, bit_value, bit_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bit_judge dut_i (
        .clk(clk), .rst(rst), .serial_in(serial_in), .bit_start(bit_start),
        .tol_sel(tol_sel), .bit_valid(bit_valid), .bit_value(bit_value),
        .bit_error(bit_error)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,value,error} actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic [2:0] expect_of(input int ones, input int sel);
        int al = 6 + 2 * sel;
        if (ones >= 32 - al) return 3'b110;
        if (ones <= al)      return 3'b100;
        return 3'b101;
    endfunction

    // Drives one cell: pat[0] in the cycle before the strobe, pat[k] k cycles later.
    // Optionally switches tol_sel to alt_sel in the middle of the window.
    task automatic run_cell(input logic [31:0] pat, input logic [1:0] sel,
                            input bit change, input logic [1:0] alt_sel,
                            input logic [2:0] exp, input string req);
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            serial_in = pat[j];
            bit_start = (j == 1);
            if (j == 1) tol_sel = sel;
            else if (change && j == 12) tol_sel = alt_sel;
            if (j >= 3) check({req, " R10 quiet in window"}, {bit_valid, bit_value, bit_error}, 3'b000);
            @(posedge clk);
        end
        @(negedge clk); serial_in = 1'b0;
        check({req, " R3 no early decision"}, {bit_valid, bit_value, bit_error}, 3'b000);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, {bit_valid, bit_value, bit_error}, exp);
        @(posedge clk);
        @(negedge clk);
        check({req, " R3 single pulse"}, {bit_valid, bit_value, bit_error}, 3'b000);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1 in reset", {bit_valid, bit_value, bit_error}, 3'b000);
        end
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {bit_valid, bit_value, bit_error}, 3'b000);

        // R4 R5 R6 R7 R2: all counts, all codes, HIGH samples at head and at tail
        for (int sel = 0; sel < 4; sel++) begin
            for (int n = 0; n <= 32; n++) begin
                for (int side = 0; side < 2; side++) begin
                    logic [31:0] p;
                    p = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
                    if (side == 1) p = ~((n == 0) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF >> n));
                    run_cell(p, 2'(sel), 1'b0, 2'b00, expect_of(n, sel),
                             "R4 R5 R6 R7 R2 sweep");
                end
            end
        end

        // R8: 9 HIGH samples; code 00 latched gives error, late code 11 would give LOW
        run_cell(32'h0000_01FF, 2'b00, 1'b1, 2'b11, 3'b101, "R8 latched select");
        // R8: 24 HIGH samples; code 11 latched gives HIGH, late code 00 would give error
        run_cell(32'h00FF_FFFF, 2'b11, 1'b1, 2'b00, 3'b110, "R8 latched select high");

        // R9: open a noisy window, then restart it with an all-LOW cell
        @(negedge clk); bit_start = 1'b1; serial_in = 1'b1; tol_sel = 2'b00;
        @(posedge clk);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk); bit_start = 1'b0; serial_in = 1'b1;
            check("R9 no pulse in aborted window", {bit_valid, bit_value, bit_error}, 3'b000);
            @(posedge clk);
        end
        run_cell(32'h0000_0000, 2'b00, 1'b0, 2'b00, 3'b100, "R9 restarted window");

        // R10: no decision without a fresh strobe, even with a busy line
        for (int j = 0; j < 40; j++) begin
            @(negedge clk); serial_in = j[0];
            check("R10 idle after decision", {bit_valid, bit_value, bit_error}, 3'b000);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule